// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This unit turns an integer operand into an IEEE 754 floating-point value in half, single or double precision. A 64-bit source word arrives with a source-format code, which gives the signedness and width of the integer. It also carries a lane select, a destination-format code and a rounding-mode code. The unit picks the requested byte or halfword lane and extends it to a 65-bit signed value. It can then take the absolute value, negate the result, or both. Finally it normalizes, rounds and packs the float.

Some width pairs are forbidden, and some lane selects do not suit the chosen source width. Either case raises an illegal flag. The flag suppresses the destination write and the condition-code write. Results leave through one register stage, marked by a valid strobe one cycle after the request. A 4-bit condition-code vector travels with each result.

Top module: `i2f_unit`

## Requirements
- R1: `src_fmt[2:1]` selects the source width (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits). `src_fmt[0]` = 1 sign-extends the selected field and 0 zero-extends it.
- R2: `dst_fmt` 0 gives half precision in `result[15:0]`, 1 gives single in `result[31:0]` and 2 gives double in `result[63:0]`. Result bits above the format width are zero.
- R3: `illegal` is 1 when `dst_fmt` = 3, when an 8- or 16-bit source targets double, or when a 32- or 64-bit source targets half.
- R4: For an 8-bit source, `lane_sel` picks byte 0..3, that is bits [7:0], [15:8], [23:16] or [31:24]. For a 16-bit source, `lane_sel[0]` picks bits [15:0] or [31:16], and `lane_sel[1]` = 1 is illegal. For 32- and 64-bit sources, any nonzero `lane_sel` is illegal.
- R5: `abs_en` takes the absolute value of the extended integer first, and `neg_en` negates it afterwards. Magnitudes are carried in 65 bits, so the most negative 64-bit value and the largest unsigned 64-bit value convert without wraparound.
- R6: `rnd_mode` selects the rounding at the mantissa LSB: 0 = nearest with ties to even, 1 = toward minus infinity, 2 = toward plus infinity, 3 = toward zero. A carry out of rounding increments the exponent.
- R7: A half-precision result that is too large becomes infinity (exponent field 31, fraction 0). Instead it becomes the largest finite value 0x7BFF with the result's sign when rounding is toward zero, or when the direction points toward zero for that sign.
- R8: A zero operand yields +0.0, an all-zero result, under every modifier and mode.
- R9: `out_valid` is `in_valid` delayed by exactly one clock, and the outputs of a request appear together with it.
- R10: With `illegal` = 1, `wr_en` and `cc_wr` stay 0 and `result` is zero.
- R11: `cc` is {zero, sign, carry, overflow} in bits [3:0], with zero = result is all zeros, sign = result sign bit, and carry = overflow = 0. `cc_wr` = 1 only for a legal result with `cc_req` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| src_bits | input | 64 | Source operand |
| src_fmt | input | 3 | Source width and signedness code |
| dst_fmt | input | 2 | Destination precision code |
| lane_sel | input | 2 | Byte or halfword lane select |
| rnd_mode | input | 2 | Rounding direction |
| abs_en | input | 1 | Take absolute value |
| neg_en | input | 1 | Negate after absolute value |
| cc_req | input | 1 | Request condition-code write |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Packed float, zero-extended |
| illegal | output | 1 | Forbidden combination flag |
| wr_en | output | 1 | Destination write enable |
| cc_wr | output | 1 | Condition-code write enable |
| cc | output | 4 | {zero, sign, carry, overflow} |

## Verification
The hardest situations to reach are two. The first is a rounding carry that ripples into the exponent. The second is half-precision overflow resolved differently by each rounding direction. Random 64-bit operands almost never land on them.

Directed vectors drive 16-bit sources near 65535 through all four modes, under both signs. They also drive the extreme 64-bit values through negate and abs. Random vectors are biased toward short, all-ones and narrow-lane operands so that ties and carries recur.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
   localparam int OPW = 64;
   localparam int NFMT = 3;

   // mantissa and exponent widths per destination index (0 half, 1 single, 2 double)
   function automatic int fmt_mw(input int idx);
      return (idx == 0) ? 10 : (idx == 1) ? 23 : 52;
   endfunction

   function automatic int fmt_ew(input int idx);
      return (idx == 0) ? 5 : (idx == 1) ? 8 : 11;
   endfunction

   function automatic logic [5:0] lead_one(input logic [OPW-1:0] v);
      logic [5:0] pos;
      pos = '0;
      for (int i = 0; i < OPW; i++)
         if (v[i]) pos = 6'(i);
      return pos;
   endfunction
endpackage

// File: rtl/i2f_legal.sv
module i2f_legal (
   input  logic [2:0] src_fmt,
   input  logic [1:0] dst_fmt,
   input  logic [1:0] lane_sel,
   output logic       illegal_o
);
   logic [1:0] wcode;
   logic       bad_pair, bad_lane;

   always_comb begin
      wcode    = src_fmt[2:1];
      // R3 width pair matrix
      bad_pair = (dst_fmt == 2'd3) ||
                 (!wcode[1] && dst_fmt == 2'd2) ||
                 (wcode[1] && dst_fmt == 2'd0);
      // R4 lane select only for narrow widths
      case (wcode)
         2'd0:    bad_lane = 1'b0;
         2'd1:    bad_lane = lane_sel[1];
         default: bad_lane = |lane_sel;
      endcase
      illegal_o = bad_pair | bad_lane;
   end
endmodule

// File: rtl/i2f_extract.sv
module i2f_extract #(
   parameter int OPW = 64
) (
   input  logic [OPW-1:0] src_bits,
   input  logic [2:0]     src_fmt,
   input  logic [1:0]     lane_sel,
   input  logic           abs_en,
   input  logic           neg_en,
   output logic           sign_o,
   output logic [OPW-1:0] mag_o
);
   localparam int XW = OPW + 1;

   logic [7:0]    byte_f;
   logic [15:0]   half_f;
   logic [XW-1:0] ext, after_abs, after_neg, flip;
   logic          sgn;

   always_comb begin
      sgn = src_fmt[0];
      case (lane_sel)
         2'd0:    byte_f = src_bits[7:0];
         2'd1:    byte_f = src_bits[15:8];
         2'd2:    byte_f = src_bits[23:16];
         default: byte_f = src_bits[31:24];
      endcase
      half_f = lane_sel[0] ? src_bits[31:16] : src_bits[15:0];
      // R1 sign or zero extension into 65 bits
      case (src_fmt[2:1])
         2'd0:    ext = {{(XW-8){sgn & byte_f[7]}}, byte_f};
         2'd1:    ext = {{(XW-16){sgn & half_f[15]}}, half_f};
         2'd2:    ext = {{(XW-32){sgn & src_bits[31]}}, src_bits[31:0]};
         default: ext = {sgn & src_bits[OPW-1], src_bits};
      endcase
      // R5 abs first, negate second, 65-bit wide
      after_abs = (abs_en && ext[XW-1]) ? (~ext + 1'b1) : ext;
      after_neg = neg_en ? (~after_abs + 1'b1) : after_abs;
      sign_o    = after_neg[XW-1];
      flip      = ~after_neg + 1'b1;
      mag_o     = sign_o ? flip[OPW-1:0] : after_neg[OPW-1:0];
   end
endmodule

// File: rtl/i2f_pack.sv
module i2f_pack
   import i2f_pkg::*;
#(
   parameter int MW = 10,
   parameter int EW = 5
) (
   input  logic           sign_i,
   input  logic [OPW-1:0] mag_i,
   input  logic [1:0]     rnd_mode,
   output logic [MW+EW:0] packed_o
);
   localparam int BIAS = (1 << (EW - 1)) - 1;
   localparam int MAXE = (1 << EW) - 1;

   if (MW + EW + 1 > OPW || MW > OPW - 4 || EW < 2)
      $error("i2f_pack: unsupported mantissa/exponent widths");

   logic [5:0]     lpos;
   logic [OPW-1:0] norm;
   logic [MW:0]    kept;
   logic [MW+1:0]  sum;
   logic           guard, sticky, inc, carry, ovf, to_inf;
   logic [15:0]    exp_b;
   logic [MW-1:0]  frac;

   always_comb begin
      lpos   = lead_one(mag_i);
      norm   = mag_i << (6'd63 - lpos);
      kept   = norm[OPW-1 -: MW+1];
      guard  = norm[OPW-2-MW];
      sticky = |norm[OPW-3-MW:0];
      // R6 rounding direction at the mantissa LSB
      case (rnd_mode)
         2'd0:    inc = guard & (sticky | kept[0]);
         2'd1:    inc = sign_i & (guard | sticky);
         2'd2:    inc = !sign_i & (guard | sticky);
         default: inc = 1'b0;
      endcase
      sum   = {1'b0, kept} + {{(MW+1){1'b0}}, inc};
      carry = sum[MW+1];
      frac  = carry ? '0 : sum[MW-1:0];
      exp_b = 16'(lpos) + 16'(BIAS) + 16'(carry);
      // R7 overflow saturation or infinity
      ovf    = exp_b >= 16'(MAXE);
      to_inf = (rnd_mode == 2'd0) || (rnd_mode == 2'd1 && sign_i) ||
               (rnd_mode == 2'd2 && !sign_i);
      if (mag_i == '0)
         packed_o = '0;                         // R8
      else if (ovf && to_inf)
         packed_o = {sign_i, {EW{1'b1}}, {MW{1'b0}}};
      else if (ovf)
         packed_o = {sign_i, EW'(MAXE - 1), {MW{1'b1}}};
      else
         packed_o = {sign_i, exp_b[EW-1:0], frac};
   end
endmodule

// File: rtl/i2f_unit.sv
module i2f_unit
   import i2f_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] src_bits,
   input  logic [2:0]        src_fmt,
   input  logic [1:0]        dst_fmt,
   input  logic [1:0]        lane_sel,
   input  logic [1:0]        rnd_mode,
   input  logic              abs_en,
   input  logic              neg_en,
   input  logic              cc_req,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              illegal,
   output logic              wr_en,
   output logic              cc_wr,
   output logic [3:0]        cc
);
   if (DATA_W != OPW)
      $error("i2f_unit: DATA_W must equal the package operand width");

   logic              bad, sgn;
   logic [OPW-1:0]    mag;
   logic [OPW-1:0]    cand [NFMT];
   logic [OPW-1:0]    res_d;

   i2f_legal u_legal (
      .src_fmt(src_fmt), .dst_fmt(dst_fmt), .lane_sel(lane_sel), .illegal_o(bad)
   );

   i2f_extract #(.OPW(OPW)) u_ext (
      .src_bits(src_bits), .src_fmt(src_fmt), .lane_sel(lane_sel),
      .abs_en(abs_en), .neg_en(neg_en), .sign_o(sgn), .mag_o(mag)
   );

   for (genvar g = 0; g < NFMT; g++) begin : g_fmt
      localparam int MW = fmt_mw(g);
      localparam int EW = fmt_ew(g);
      logic [MW+EW:0] pk;
      i2f_pack #(.MW(MW), .EW(EW)) u_pack (
         .sign_i(sgn), .mag_i(mag), .rnd_mode(rnd_mode), .packed_o(pk)
      );
      if (MW + EW + 1 < OPW) begin : g_pad
         assign cand[g] = {{(OPW-MW-EW-1){1'b0}}, pk};
      end else begin : g_full
         assign cand[g] = pk;
      end
   end

   // R2 destination lane placement
   always_comb begin
      if (bad)
         res_d = '0;
      else
         res_d = cand[dst_fmt];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         illegal   <= 1'b0;
         wr_en     <= 1'b0;
         cc_wr     <= 1'b0;
         cc        <= '0;
      end else begin
         out_valid <= in_valid;
         result    <= res_d;
         illegal   <= in_valid & bad;
         wr_en     <= in_valid & !bad;
         cc_wr     <= in_valid & !bad & cc_req;
         cc        <= {res_d == '0, sgn & !bad & (mag != '0), 2'b00};
      end
   end

   // R9
   latency_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R9
   latency_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !wr_en);
   // R10
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> out_valid && !wr_en && !cc_wr && result == '0);
   // R11
   cc_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cc_wr |-> wr_en && cc[1:0] == 2'b00 && cc[3] == (result == '0));
   // R10
   legal_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !illegal |-> wr_en);
endmodule

// File: tb/i2f_unit_test.sv
module i2f_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] src_bits = '0;
   logic [2:0]  src_fmt = '0;
   logic [1:0]  dst_fmt = '0;
   logic [1:0]  lane_sel = '0;
   logic [1:0]  rnd_mode = '0;
   logic        abs_en = 1'b0, neg_en = 1'b0, cc_req = 1'b0;
   logic        out_valid, illegal, wr_en, cc_wr;
   logic [63:0] result;
   logic [3:0]  cc;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2f_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_bits(src_bits),
      .src_fmt(src_fmt), .dst_fmt(dst_fmt), .lane_sel(lane_sel),
      .rnd_mode(rnd_mode), .abs_en(abs_en), .neg_en(neg_en), .cc_req(cc_req),
      .out_valid(out_valid), .result(result), .illegal(illegal),
      .wr_en(wr_en), .cc_wr(cc_wr), .cc(cc)
   );

   function automatic bit ref_illegal(logic [2:0] sf, logic [1:0] df, logic [1:0] ls);
      int w = int'(sf[2:1]);
      bit bp = (df == 3) || (w <= 1 && df == 2) || (w >= 2 && df == 0);
      bit bl = (w == 1 && ls[1]) || (w >= 2 && ls != 0);
      return bp || bl;
   endfunction

   function automatic logic [63:0] ref_round(bit s, logic [63:0] m, int mw, int ew,
                                             logic [1:0] rm);
      int p = 0, e, bias, maxe;
      logic [63:0] q, rem, hv, r;
      bit up;
      if (m == 0) return 64'd0;
      for (int i = 0; i < 64; i++) if (m[i]) p = i;
      if (p <= mw) q = m << (mw - p);
      else begin
         q   = m >> (p - mw);
         rem = m & ((64'd1 << (p - mw)) - 64'd1);
         hv  = 64'd1 << (p - mw - 1);
         case (rm)
            2'd0: up = (rem > hv) || (rem == hv && q[0]);
            2'd1: up = s && rem != 0;
            2'd2: up = !s && rem != 0;
            default: up = 1'b0;
         endcase
         q = q + 64'(up);
         if (q == (64'd1 << (mw + 1))) begin q = q >> 1; p = p + 1; end
      end
      bias = (1 << (ew - 1)) - 1;
      maxe = (1 << ew) - 1;
      e = p + bias;
      if (e >= maxe) begin
         if (rm == 0 || (rm == 1 && s) || (rm == 2 && !s))
            r = (64'(s) << (mw + ew)) | (64'(maxe) << mw);
         else
            r = (64'(s) << (mw + ew)) | (64'(maxe - 1) << mw) | ((64'd1 << mw) - 64'd1);
      end else
         r = (64'(s) << (mw + ew)) | (64'(e) << mw) | (q & ((64'd1 << mw) - 64'd1));
      return r;
   endfunction

   function automatic logic [63:0] ref_result(logic [63:0] sb, logic [2:0] sf,
      logic [1:0] df, logic [1:0] ls, logic [1:0] rm, bit ab, bit ng);
      logic signed [65:0] v;
      logic [63:0] fld;
      int wb;
      bit s;
      if (ref_illegal(sf, df, ls)) return 64'd0;
      wb = 8 << sf[2:1];
      if (wb == 8) fld = (sb >> (8 * ls)) & 64'hFF;
      else if (wb == 16) fld = (sb >> (16 * ls[0])) & 64'hFFFF;
      else if (wb == 32) fld = sb & 64'hFFFF_FFFF;
      else fld = sb;
      v = $signed({2'b00, fld});
      if (sf[0] && fld[wb-1]) v = v - (66'sd1 <<< wb);
      if (ab && v < 0) v = -v;
      if (ng) v = -v;
      s = v < 0;
      if (s) v = -v;
      case (df)
         2'd0: return ref_round(s, v[63:0], 10, 5, rm);
         2'd1: return ref_round(s, v[63:0], 23, 8, rm);
         default: return ref_round(s, v[63:0], 52, 11, rm);
      endcase
   endfunction

   task automatic fail_line(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
   endtask

   task automatic apply(string tag, logic [63:0] sb, logic [2:0] sf, logic [1:0] df,
                        logic [1:0] ls, logic [1:0] rm, bit ab, bit ng, bit cq);
      logic [63:0] er;
      bit eb, ev;
      logic [3:0] ecc;
      @(negedge clk);
      in_valid = 1'b1; src_bits = sb; src_fmt = sf; dst_fmt = df; lane_sel = ls;
      rnd_mode = rm; abs_en = ab; neg_en = ng; cc_req = cq;
      er  = ref_result(sb, sf, df, ls, rm, ab, ng);
      eb  = ref_illegal(sf, df, ls);
      ev  = !eb;
      ecc = {er == 0, (df == 0) ? er[15] : (df == 1) ? er[31] : er[63], 2'b00};
      @(negedge clk);
      in_valid = 1'b0;
      n_vec++;
      if (result !== er) fail_line(tag, "result", result, er);
      else if (illegal !== eb) fail_line(tag, "illegal", 64'(illegal), 64'(eb));
      else if (out_valid !== 1'b1) fail_line(tag, "out_valid", 64'(out_valid), 64'd1);
      else if (wr_en !== ev) fail_line(tag, "wr_en", 64'(wr_en), 64'(ev));
      else if (cc_wr !== (ev && cq)) fail_line(tag, "cc_wr", 64'(cc_wr), 64'(ev && cq));
      else if (ev && cc !== ecc) fail_line(tag, "cc", 64'(cc), 64'(ecc));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      n_vec++;
      if (out_valid !== 1'b0 || wr_en !== 1'b0 || result !== 64'd0)
         fail_line("R9", "reset state", {out_valid, wr_en, 62'(result)}, 64'd0);
      rst_n = 1'b1;

      // R1 extension
      apply("R1", 64'h80, 3'd1, 2'd1, 2'd0, 2'd0, 0, 0, 1);
      apply("R1", 64'h80, 3'd0, 2'd1, 2'd0, 2'd0, 0, 0, 1);
      apply("R1", 64'hFFFF_FFFF, 3'd5, 2'd2, 2'd0, 2'd0, 0, 0, 1);
      // R2 placement of three precisions
      apply("R2", 64'd1000, 3'd2, 2'd0, 2'd0, 2'd0, 0, 0, 0);
      apply("R2", 64'd1000, 3'd4, 2'd1, 2'd0, 2'd0, 0, 0, 0);
      apply("R2", 64'd1000, 3'd6, 2'd2, 2'd0, 2'd0, 0, 0, 0);
      // R3 forbidden pairs
      apply("R3", 64'd5, 3'd0, 2'd2, 2'd0, 2'd0, 0, 0, 1);
      apply("R3", 64'd5, 3'd4, 2'd0, 2'd0, 2'd0, 0, 0, 1);
      apply("R3", 64'd5, 3'd7, 2'd3, 2'd0, 2'd0, 0, 0, 1);
      // R4 lanes
      apply("R4", 64'h8844_2211, 3'd1, 2'd0, 2'd3, 2'd0, 0, 0, 1);
      apply("R4", 64'h8844_2211, 3'd0, 2'd1, 2'd2, 2'd0, 0, 0, 1);
      apply("R4", 64'h9000_0001, 3'd3, 2'd1, 2'd1, 2'd0, 0, 0, 1);
      apply("R4", 64'h9000_0001, 3'd3, 2'd1, 2'd2, 2'd0, 0, 0, 1);
      apply("R4", 64'h9000_0001, 3'd4, 2'd1, 2'd1, 2'd0, 0, 0, 1);
      // R5 extreme values through modifiers
      apply("R5", 64'h8000_0000_0000_0000, 3'd7, 2'd2, 2'd0, 2'd0, 0, 1, 1);
      apply("R5", 64'h8000_0000_0000_0000, 3'd7, 2'd2, 2'd0, 2'd0, 1, 1, 1);
      apply("R5", 64'hFFFF_FFFF_FFFF_FFFF, 3'd6, 2'd1, 2'd0, 2'd1, 0, 1, 1);
      apply("R5", 64'hFFFF_FFFF_FFFF_FFFF, 3'd6, 2'd2, 2'd0, 2'd3, 0, 1, 1);
      // R6 ties and carries
      for (int m = 0; m < 4; m++) begin
         apply("R6", 64'd2049, 3'd2, 2'd0, 2'd0, 2'(m), 0, 0, 1);
         apply("R6", 64'd2051, 3'd2, 2'd0, 2'd0, 2'(m), 0, 1, 1);
         apply("R6", 64'h1FF_FFFF, 3'd5, 2'd1, 2'd0, 2'(m), 0, 0, 1);
         // R7 half overflow under each mode and sign
         apply("R7", 64'hFFFF, 3'd2, 2'd0, 2'd0, 2'(m), 0, 0, 1);
         apply("R7", 64'hFFFF, 3'd2, 2'd0, 2'd0, 2'(m), 0, 1, 1);
         apply("R7", 64'hFFE0, 3'd2, 2'd0, 2'd0, 2'(m), 0, 0, 1);
      end
      // R8 zero
      apply("R8", 64'h0, 3'd7, 2'd2, 2'd0, 2'd1, 1, 1, 1);
      apply("R8", 64'h00FF_0000, 3'd1, 2'd0, 2'd0, 2'd2, 0, 1, 1);
      // R9 idle cycle: no output strobe
      @(negedge clk);
      n_vec++;
      if (out_valid !== 1'b0) fail_line("R9", "idle out_valid", 64'(out_valid), 64'd0);
      // R10 R11 random mix
      for (int k = 0; k < 3000; k++) begin
         logic [63:0] sb;
         logic [2:0]  sf = 3'($urandom);
         logic [1:0]  df = 2'($urandom);
         logic [1:0]  ls = ($urandom_range(0, 3) == 0) ? 2'($urandom) :
                           (sf[2:1] == 0) ? 2'($urandom) :
                           (sf[2:1] == 1) ? {1'b0, 1'($urandom)} : 2'd0;
         case ($urandom_range(0, 3))
            0: sb = {$urandom, $urandom};
            1: sb = 64'($urandom_range(0, 300));
            2: sb = ~64'd0 >> $urandom_range(0, 63);
            default: sb = {$urandom, $urandom} >> $urandom_range(0, 63);
         endcase
         apply("R10,R11,R6", sb, sf, df, ls, 2'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom));
      end
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule